// File: doc/BRIEF.md
# Layer-2 Address-Learning Forwarding Engine

This block makes the forwarding decision for a small Ethernet switch. Each frame header is presented once, as an ingress port number, a 48-bit destination address and a 48-bit source address, under a valid/ready handshake. One clock cycle after the header is accepted, the block presents a registered bitmask of the egress ports that should receive the frame. Frame storage and the data path are handled elsewhere; only the decision is made here.

Source addresses are learned into a small fully associative table, which records which port each station was last seen on. Destination addresses are looked up in the same table. All-ones destinations are sent to every port. Group-addressed destinations are sent only to ports that have joined the multicast membership mask. Unicast destinations that are not in the table are either discarded or flooded, depending on a policy bit. Software sets the policy bit and the membership mask through a small write-only register port. A synchronous clear input empties the table.

Top module: `l2_fwd_engine`

## Requirements
- R1: A header accepted on a rising edge (hdr_valid and hdr_ready both high) produces dec_valid high for exactly the following cycle, with the decision on dec_mask. dec_mask is zero whenever dec_valid is low.
- R2: A destination equal to all ones (FF:FF:FF:FF:FF:FF) yields a mask with every port set except the ingress port. ARP and other broadcast frames are treated no differently.
- R3: Bit n of dec_mask stands for port n. The ingress port bit is always zero, so a destination learned on the ingress port yields an empty mask.
- R4: An accepted frame whose source address has bit 40 clear (the least significant bit of the first octet) records that address against its ingress port. A later unicast frame to that address yields a mask with only that port set.
- R5: When a source address already in the table arrives on a different port, the entry moves to the new port. It does not take a second entry.
- R6: A unicast destination (bit 40 clear) that is not in the table yields an empty mask when the flood policy bit is 0, and every port except the ingress port when it is 1. The policy bit is bit 0 of cfg_wdata, written with cfg_we high and cfg_addr 0.
- R7: A destination with bit 40 set that is not all ones is multicast. Its mask is the membership mask with the ingress port removed, so it is empty when no port has joined. The membership mask is cfg_wdata, written with cfg_we high and cfg_addr 1.
- R8: A source address with bit 40 set is never learned and occupies no table entry.
- R9: A frame's destination lookup sees the table as it was before that frame's own source was learned.
- R10: A new source learned into a full table replaces an entry chosen by a round-robin pointer. Free entries fill from index 0 upward. The pointer starts at entry 0 and advances by one on each replacement, so the oldest-filled entries are evicted in order.
- R11: With tbl_clear high, hdr_ready is low and every table entry is invalidated on that edge.
- R12: After reset, dec_valid is low, the table is empty, the flood policy bit is 0 and the membership mask is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_clear | input | 1 | Invalidate all table entries this cycle |
| hdr_valid | input | 1 | Header fields are valid |
| hdr_ready | output | 1 | Engine can accept a header this cycle |
| hdr_port | input | PORT_W (2) | Ingress port number |
| hdr_dst | input | 48 | Destination address, first octet in bits 47:40 |
| hdr_src | input | 48 | Source address, first octet in bits 47:40 |
| dec_valid | output | 1 | Decision valid this cycle |
| dec_mask | output | NUM_PORTS (4) | Egress port bitmask |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 1 | 0: flood policy, 1: multicast membership |
| cfg_wdata | input | NUM_PORTS (4) | Configuration write data |

## Verification
The assertions assume that hdr_valid is held low while reset is asserted. They also assume that hdr_port always names an existing port and that header fields carry no unknown bits when hdr_valid is high. The stimulus drives every input on the falling clock edge from fully defined values and keeps the ingress port within 0 to 3. It presents one header at a time, each followed by an idle cycle, which keeps the decision-timing properties unambiguous. Configuration writes and table clears are never issued in the same cycle as a header.

// File: rtl/l2fwd_pkg.sv
package l2fwd_pkg;

    localparam int MAC_W     = 48;
    localparam int GROUP_BIT = 40;

    localparam logic CFG_SEL_POLICY  = 1'b0;
    localparam logic CFG_SEL_MEMBERS = 1'b1;

    typedef enum logic [1:0] {
        KIND_UNICAST   = 2'd0,
        KIND_MULTICAST = 2'd1,
        KIND_BROADCAST = 2'd2
    } dst_kind_e;

    function automatic logic is_group(input logic [MAC_W-1:0] mac);
        return mac[GROUP_BIT];
    endfunction

    function automatic dst_kind_e classify(input logic [MAC_W-1:0] mac);
        if (&mac)
            return KIND_BROADCAST;
        else if (mac[GROUP_BIT])
            return KIND_MULTICAST;
        else
            return KIND_UNICAST;
    endfunction

endpackage

// File: rtl/l2fwd_cam.sv
module l2fwd_cam
    import l2fwd_pkg::*;
#(
    parameter int DEPTH     = 16,
    parameter int NUM_PORTS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear_i,
    input  logic [MAC_W-1:0]     lookup_mac_i,
    output logic                 lookup_hit_o,
    output logic [PW-1:0]        lookup_port_o,
    input  logic                 learn_en_i,
    input  logic [MAC_W-1:0]     learn_mac_i,
    input  logic [PW-1:0]        learn_port_i
);
    localparam int PW    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

    typedef struct packed {
        logic             valid;
        logic [MAC_W-1:0] mac;
        logic [PW-1:0]    port;
    } entry_t;

    typedef struct packed {
        entry_t [DEPTH-1:0] tbl;
        logic [IDX_W-1:0]   victim;
    } cam_state_t;

    cam_state_t cur_q, nxt_d;

    logic [DEPTH-1:0] dst_match;
    logic [DEPTH-1:0] src_match;
    logic [DEPTH-1:0] slot_free;

    // match vectors for both addresses, against the registered table
    generate
        for (genvar gi = 0; gi < DEPTH; gi++) begin : g_cmp
            assign dst_match[gi] = cur_q.tbl[gi].valid && (cur_q.tbl[gi].mac == lookup_mac_i);
            assign src_match[gi] = cur_q.tbl[gi].valid && (cur_q.tbl[gi].mac == learn_mac_i);
            assign slot_free[gi] = !cur_q.tbl[gi].valid;
        end
    endgenerate

    logic             src_hit;
    logic [IDX_W-1:0] src_idx;
    logic             free_any;
    logic [IDX_W-1:0] free_idx;

    always_comb begin
        lookup_hit_o  = 1'b0;
        lookup_port_o = '0;
        src_hit       = 1'b0;
        src_idx       = '0;
        free_any      = 1'b0;
        free_idx      = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (dst_match[i] && !lookup_hit_o) begin
                lookup_hit_o  = 1'b1;
                lookup_port_o = cur_q.tbl[i].port;
            end
            if (src_match[i] && !src_hit) begin
                src_hit = 1'b1;
                src_idx = IDX_W'(i);
            end
            if (slot_free[i] && !free_any) begin
                free_any = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
    end

    always_comb begin
        nxt_d = cur_q;
        if (clear_i) begin
            for (int i = 0; i < DEPTH; i++) begin
                nxt_d.tbl[i].valid = 1'b0;
            end
            nxt_d.victim = '0;
        end else if (learn_en_i) begin
            if (src_hit) begin
                nxt_d.tbl[src_idx].port = learn_port_i;
            end else if (free_any) begin
                nxt_d.tbl[free_idx] = '{valid: 1'b1, mac: learn_mac_i, port: learn_port_i};
            end else begin
                nxt_d.tbl[cur_q.victim] = '{valid: 1'b1, mac: learn_mac_i, port: learn_port_i};
                nxt_d.victim = (cur_q.victim == LAST_IDX) ? '0 : cur_q.victim + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

endmodule

// File: rtl/l2fwd_decide.sv
module l2fwd_decide
    import l2fwd_pkg::*;
#(
    parameter int NUM_PORTS = 4
) (
    input  logic [MAC_W-1:0]     dst_i,
    input  logic [PW-1:0]        ingress_i,
    input  logic                 hit_i,
    input  logic [PW-1:0]        hit_port_i,
    input  logic                 flood_unknown_i,
    input  logic [NUM_PORTS-1:0] members_i,
    output logic [NUM_PORTS-1:0] mask_o
);
    localparam int PW = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;
    localparam logic [NUM_PORTS-1:0] ALL_PORTS = '1;
    localparam logic [NUM_PORTS-1:0] ONE       = NUM_PORTS'(1);

    dst_kind_e            kind;
    logic [NUM_PORTS-1:0] raw_mask;
    logic [NUM_PORTS-1:0] ingress_bit;

    always_comb begin
        kind        = classify(dst_i);
        ingress_bit = ONE << ingress_i;
        unique case (kind)
            KIND_BROADCAST: raw_mask = ALL_PORTS;
            KIND_MULTICAST: raw_mask = members_i;
            default: begin
                if (hit_i)
                    raw_mask = ONE << hit_port_i;
                else
                    raw_mask = flood_unknown_i ? ALL_PORTS : '0;
            end
        endcase
        mask_o = raw_mask & ~ingress_bit;
    end

endmodule

// File: rtl/l2_fwd_engine.sv
module l2_fwd_engine
    import l2fwd_pkg::*;
#(
    parameter int NUM_PORTS   = 4,
    parameter int TABLE_DEPTH = 16,
    localparam int PORT_W     = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tbl_clear,
    input  logic                 hdr_valid,
    output logic                 hdr_ready,
    input  logic [PORT_W-1:0]    hdr_port,
    input  logic [MAC_W-1:0]     hdr_dst,
    input  logic [MAC_W-1:0]     hdr_src,
    output logic                 dec_valid,
    output logic [NUM_PORTS-1:0] dec_mask,
    input  logic                 cfg_we,
    input  logic                 cfg_addr,
    input  logic [NUM_PORTS-1:0] cfg_wdata
);

    typedef struct packed {
        logic                 dec_valid;
        logic [NUM_PORTS-1:0] dec_mask;
        logic                 flood_unknown;
        logic [NUM_PORTS-1:0] members;
    } eng_state_t;

    eng_state_t cur_q, nxt_d;

    logic                 accept;
    logic                 learn_en;
    logic                 lkp_hit;
    logic [PORT_W-1:0]    lkp_port;
    logic [NUM_PORTS-1:0] fwd_mask;
    logic [NUM_PORTS-1:0] members_cur;

    assign hdr_ready   = !tbl_clear;
    assign accept      = hdr_valid && hdr_ready;
    assign learn_en    = accept && !is_group(hdr_src);
    assign members_cur = cur_q.members;

    l2fwd_cam #(
        .DEPTH     (TABLE_DEPTH),
        .NUM_PORTS (NUM_PORTS)
    ) cam_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear_i      (tbl_clear),
        .lookup_mac_i (hdr_dst),
        .lookup_hit_o (lkp_hit),
        .lookup_port_o(lkp_port),
        .learn_en_i   (learn_en),
        .learn_mac_i  (hdr_src),
        .learn_port_i (hdr_port)
    );

    l2fwd_decide #(
        .NUM_PORTS (NUM_PORTS)
    ) decide_i (
        .dst_i          (hdr_dst),
        .ingress_i      (hdr_port),
        .hit_i          (lkp_hit),
        .hit_port_i     (lkp_port),
        .flood_unknown_i(cur_q.flood_unknown),
        .members_i      (cur_q.members),
        .mask_o         (fwd_mask)
    );

    always_comb begin
        nxt_d           = cur_q;
        nxt_d.dec_valid = accept;
        nxt_d.dec_mask  = accept ? fwd_mask : '0;
        if (cfg_we) begin
            if (cfg_addr == CFG_SEL_POLICY)
                nxt_d.flood_unknown = cfg_wdata[0];
            else
                nxt_d.members = cfg_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign dec_valid = cur_q.dec_valid;
    assign dec_mask  = cur_q.dec_mask;

endmodule

// File: rtl/l2fwd_checker.sv
module l2fwd_checker
    import l2fwd_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int PORT_W    = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 hdr_valid,
    input logic                 hdr_ready,
    input logic [PORT_W-1:0]    hdr_port,
    input logic [MAC_W-1:0]     hdr_dst,
    input logic                 dec_valid,
    input logic [NUM_PORTS-1:0] dec_mask,
    input logic [NUM_PORTS-1:0] members_cur
);
    localparam logic [NUM_PORTS-1:0] ONE = NUM_PORTS'(1);

    logic acc;
    assign acc = hdr_valid && hdr_ready;

    a_r1_decision_next: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> dec_valid);

    a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> !dec_valid);

    a_r1_idle_mask_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |-> (dec_mask == '0));

    a_r3_ingress_excluded: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> ((dec_mask & (ONE << $past(hdr_port))) == '0));

    a_r2_broadcast_all: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && (&hdr_dst)) |=> (dec_mask == ~(ONE << $past(hdr_port))));

    a_r7_mcast_subset: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && hdr_dst[GROUP_BIT] && !(&hdr_dst)) |=> ((dec_mask & ~$past(members_cur)) == '0));

endmodule

bind l2_fwd_engine l2fwd_checker #(
    .NUM_PORTS (NUM_PORTS),
    .PORT_W    (PORT_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .hdr_valid  (hdr_valid),
    .hdr_ready  (hdr_ready),
    .hdr_port   (hdr_port),
    .hdr_dst    (hdr_dst),
    .dec_valid  (dec_valid),
    .dec_mask   (dec_mask),
    .members_cur(members_cur)
);

// File: tb/l2_fwd_engine_tb_top.sv
module l2_fwd_engine_tb_top;

    localparam int NP = 4;
    localparam logic [47:0] BCAST = 48'hFFFF_FFFF_FFFF;
    localparam logic [47:0] STA1  = 48'h0200_0000_0001;
    localparam logic [47:0] UNK   = 48'h0200_0000_00FF;
    localparam logic [47:0] MCDST = 48'h0100_5E00_0001;
    localparam logic [47:0] GSRC  = 48'h0100_0000_00AA;
    localparam logic [47:0] PROBE = 48'h0300_0000_0099;
    localparam logic [47:0] NEWB  = 48'h0200_0000_0B0B;
    localparam logic [47:0] NEWC  = 48'h0200_0000_0C0C;
    localparam logic [47:0] SELFX = 48'h0200_0000_0777;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tbl_clear = 1'b0;
    logic          hdr_valid = 1'b0;
    logic          hdr_ready;
    logic [1:0]    hdr_port = '0;
    logic [47:0]   hdr_dst = '0;
    logic [47:0]   hdr_src = '0;
    logic          dec_valid;
    logic [NP-1:0] dec_mask;
    logic          cfg_we = 1'b0;
    logic          cfg_addr = 1'b0;
    logic [NP-1:0] cfg_wdata = '0;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #10 clk = ~clk;

    l2_fwd_engine #(.NUM_PORTS(NP), .TABLE_DEPTH(16)) dut_i (
        .clk(clk), .rst_n(rst_n), .tbl_clear(tbl_clear),
        .hdr_valid(hdr_valid), .hdr_ready(hdr_ready), .hdr_port(hdr_port),
        .hdr_dst(hdr_dst), .hdr_src(hdr_src),
        .dec_valid(dec_valid), .dec_mask(dec_mask),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata)
    );

    function automatic logic [47:0] sta(input int i);
        return 48'h0200_0000_1000 + 48'(i);
    endfunction

    function automatic logic [NP-1:0] bit_of(input int p);
        return NP'(1) << p;
    endfunction

    function automatic logic [NP-1:0] others(input int p);
        return ~bit_of(p);
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    // drive one header for one cycle; the decision is visible on the next falling edge
    task automatic send(input string req, input int p, input logic [47:0] dst,
                        input logic [47:0] src, input logic [NP-1:0] exp);
        @(negedge clk);
        hdr_valid = 1'b1;
        hdr_port  = 2'(p);
        hdr_dst   = dst;
        hdr_src   = src;
        @(negedge clk);
        hdr_valid = 1'b0;
        check({req, " valid"}, 32'(dec_valid), 32'd1);
        check({req, " mask"}, 32'(dec_mask), 32'(exp));
    endtask

    task automatic cfg_write(input logic sel, input logic [NP-1:0] data);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_addr  = sel;
        cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic clear_table();
        @(negedge clk);
        tbl_clear = 1'b1;
        #1 check("R11 ready low in clear", 32'(hdr_ready), 32'd0);
        @(negedge clk);
        tbl_clear = 1'b0;
    endtask

    task automatic t_reset();
        check("R12 reset dec_valid", 32'(dec_valid), 32'd0);
        check("R12 reset dec_mask", 32'(dec_mask), 32'd0);
        check("R12 reset ready", 32'(hdr_ready), 32'd1);
        send("R12 policy drops unknown", 0, UNK, PROBE, 4'b0000);
        send("R12 no members", 0, MCDST, PROBE, 4'b0000);
    endtask

    task automatic t_broadcast();
        send("R2 broadcast from port2", 2, BCAST, STA1, others(2));
        @(negedge clk);
        check("R1 valid drops after one cycle", 32'(dec_valid), 32'd0);
        check("R1 idle mask zero", 32'(dec_mask), 32'd0);
        send("R2 broadcast from port0", 0, BCAST, PROBE, others(0));
    endtask

    task automatic t_unknown();
        send("R6 unknown dropped", 0, UNK, PROBE, 4'b0000);
        cfg_write(1'b0, 4'b0001);
        send("R6 unknown flooded", 1, UNK, PROBE, others(1));
        cfg_write(1'b0, 4'b0000);
        send("R6 unknown dropped again", 3, UNK, PROBE, 4'b0000);
    endtask

    task automatic t_learn_move();
        send("R4 learned unicast", 0, STA1, PROBE, bit_of(2));
        send("R3 dest on ingress", 2, STA1, PROBE, 4'b0000);
        send("R5 relearn on port3", 3, BCAST, STA1, others(3));
        send("R5 moved entry", 0, STA1, PROBE, bit_of(3));
    endtask

    task automatic t_multicast();
        send("R7 no members drop", 0, MCDST, PROBE, 4'b0000);
        cfg_write(1'b1, 4'b1011);
        send("R7 members minus ingress p1", 1, MCDST, PROBE, 4'b1001);
        send("R7 members minus ingress p2", 2, MCDST, PROBE, 4'b1011);
        cfg_write(1'b1, 4'b0000);
    endtask

    task automatic t_clear();
        clear_table();
        send("R11 entry gone after clear", 0, STA1, PROBE, 4'b0000);
    endtask

    task automatic t_lookup_first();
        send("R9 self-addressed unknown", 1, SELFX, SELFX, 4'b0000);
        send("R9 learned afterwards", 0, SELFX, PROBE, bit_of(1));
    endtask

    // fill with a group-source frame in between; if it took an entry, sta(0) would be evicted
    task automatic t_group_and_replace();
        clear_table();
        send("R8 learn sta0", 0, BCAST, sta(0), others(0));
        send("R8 group source", 1, BCAST, GSRC, others(1));
        for (int i = 1; i < 16; i++) begin
            send("R10 fill", i % 4, BCAST, sta(i), others(i % 4));
        end
        send("R8 sta0 kept", 1, sta(0), PROBE, bit_of(0));
        send("R10 first victim", 2, BCAST, NEWB, others(2));
        send("R10 entry0 evicted", 1, sta(0), PROBE, 4'b0000);
        send("R10 entry1 kept", 2, sta(1), PROBE, bit_of(1));
        send("R10 second victim", 3, BCAST, NEWC, others(3));
        send("R10 entry1 evicted", 2, sta(1), PROBE, 4'b0000);
        send("R10 entry2 kept", 3, sta(2), PROBE, bit_of(2));
        send("R10 newB kept", 0, NEWB, PROBE, bit_of(2));
        send("R10 newC kept", 0, NEWC, PROBE, bit_of(3));
        send("R10 entry15 kept", 0, sta(15), PROBE, bit_of(3));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_broadcast();
        t_unknown();
        t_learn_move();
        t_multicast();
        t_clear();
        t_lookup_first();
        t_group_and_replace();
        repeat (2) @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule